// File: doc/BRIEF.md
# Flash Program/Erase Status Controller

This block models the internal write sequencer of a flash device as software sees it through an 8-bit status byte. Decoded single-cycle command strobes start a word program or a block erase, suspend or resume it, or clear the error flags. The block checks each request against hardware block protection and the programming-voltage input. It then runs the operation as a train of fixed-length pulses, each followed by a verify cycle. It reports readiness, suspension and failure causes in the status byte.

Protection covers only the two boot parameter blocks. Which two blocks these are depends on whether the boot area sits at the top or the bottom of the block range. The voltage input is looked at only when a command is taken and again in the verify cycle. Error flags stay set until software clears them while the sequencer is ready. A resumed operation carries on from the cycle where it was halted.

Top module: `flash_wsm_status`

## Requirements
- R1: After reset the status byte reads 0x80. Bit positions from 7 down to 0 are: ready (1 = ready, 0 = busy), erase suspended, erase failure, program failure, voltage abort, program suspended, locked-block abort, reserved. The reserved bit 0 always reads 0.
- R2: When ready and not suspended, an accepted program or erase strobe clears bit 7 at the next edge. Each pulse lasts PULSE_CYC cycles and is followed by one verify cycle. With PULSE_CYC = 4, a passing operation is busy for exactly 5 cycles and then reads 0x80.
- R3: An erase whose verify fails is retried with a new pulse, up to MAX_PULSES pulses in total. It then sets bit 5: with defaults that is 15 busy cycles and then 0xA0. A program whose verify fails sets bit 4 after its single pulse (0x90 after 5 cycles).
- R4: The voltage-OK input is sampled only when a command is accepted and in the verify cycle. If it is low at either point, the operation is aborted and bit 3 is set. If it is low only between those points, the operation still completes.
- R5: With write-protect low, blocks NUM_BLOCKS-2 and NUM_BLOCKS-1 are locked when boot-top is 1, and blocks 0 and 1 are locked when boot-top is 0. A program or erase to a locked block never goes busy and sets bit 1. The lock check takes priority over the voltage check. With write-protect high, no block is locked.
- R6: Program and erase strobes together while ready form a sequence error. Bits 5 and 4 are set, bit 7 stays 1, and no operation starts.
- R7: A suspend during a pulse halts the operation. For an erase it sets bits 7 and 6 (0xC0); for a program it sets bits 7 and 2 (0x84). A suspend while idle or in the verify cycle is ignored. Program and erase strobes are ignored while suspended.
- R8: A resume while suspended clears the suspend bit and bit 7 at the next edge. The pulse then finishes its remaining cycles rather than restarting. A resume when not suspended is ignored.
- R9: Bits 5, 4, 3 and 1 are sticky. A clear strobe resets them only while bit 7 is 1 and is ignored while busy. A program or erase strobe in the same cycle as a clear is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_program | input | 1 | Word program strobe |
| cmd_erase | input | 1 | Block erase strobe |
| cmd_suspend | input | 1 | Suspend strobe |
| cmd_resume | input | 1 | Resume strobe |
| cmd_clear | input | 1 | Clear error flags strobe |
| blk_idx | input | BLK_W | Target block index |
| wp_n | input | 1 | Write protect, low locks boot blocks |
| boot_top | input | 1 | 1 = boot blocks at top of range, 0 = at bottom |
| vpp_ok | input | 1 | Programming voltage adequate |
| verify_fail | input | 1 | Injected verify failure for the current verify cycle |
| status | output | 8 | Status byte |

## Verification
Two functions can meet in one cycle: a suspend strobe landing on the verify cycle of a program, and a clear strobe landing on a program strobe. The first is provoked by counting four pulse cycles after acceptance and then driving suspend. It passes only if the operation completes and the byte reads 0x80 rather than 0x84. The second is driven while error flags are set, and passes only if the flags drop and the block stays ready with no busy cycle.

// File: rtl/flash_wsm_pkg.sv
package flash_wsm_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_RUN    = 2'd1,
      ST_VERIFY = 2'd2,
      ST_SUSP   = 2'd3
   } wsm_state_t;

   typedef enum logic {
      OP_PROG  = 1'b0,
      OP_ERASE = 1'b1
   } wsm_op_t;
endpackage

// File: rtl/wsm_lock_check.sv
module wsm_lock_check #(
   parameter int NUM_BLOCKS = 8,
   parameter int BLK_W      = 3
) (
   input  logic [BLK_W-1:0] blk_idx,
   input  logic             wp_n,
   input  logic             boot_top,
   output logic             locked
);
   localparam logic [BLK_W-1:0] TOP_FIRST = BLK_W'(NUM_BLOCKS - 2);
   localparam logic [BLK_W-1:0] BOT_LAST  = BLK_W'(1);

   logic in_boot;
   always_comb begin
      if (boot_top) in_boot = (blk_idx >= TOP_FIRST);
      else          in_boot = (blk_idx <= BOT_LAST);
   end
   assign locked = !wp_n && in_boot;
endmodule

// File: rtl/wsm_pulse_timer.sv
module wsm_pulse_timer #(
   parameter int PULSE_CYC  = 4,
   parameter int MAX_PULSES = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic tick,
   input  logic next_pulse,
   output logic pulse_end,
   output logic last_pulse
);
   localparam int CYC_W = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
   localparam int PLS_W = (MAX_PULSES > 1) ? $clog2(MAX_PULSES) : 1;
   localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(PULSE_CYC - 1);

   logic [CYC_W-1:0] cyc_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                   cyc_q <= '0;
      else if (restart || next_pulse) cyc_q <= '0;
      else if (tick && !pulse_end)  cyc_q <= cyc_q + 1'b1;
   end
   assign pulse_end = (cyc_q == CYC_LAST);

   generate
      if (MAX_PULSES > 1) begin : g_multi
         localparam logic [PLS_W-1:0] PLS_LAST = PLS_W'(MAX_PULSES - 1);
         logic [PLS_W-1:0] pls_q;
         always_ff @(posedge clk) begin
            if (!rst_n)          pls_q <= '0;
            else if (restart)    pls_q <= '0;
            else if (next_pulse) pls_q <= pls_q + 1'b1;
         end
         assign last_pulse = (pls_q == PLS_LAST);
      end else begin : g_single
         assign last_pulse = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/wsm_sequencer.sv
module wsm_sequencer
   import flash_wsm_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_program,
   input  logic       cmd_erase,
   input  logic       cmd_suspend,
   input  logic       cmd_resume,
   input  logic       cmd_clear,
   input  logic       locked,
   input  logic       vpp_ok,
   input  logic       verify_fail,
   input  logic       pulse_end,
   input  logic       last_pulse,
   output wsm_state_t state,
   output wsm_op_t    op,
   output logic       restart,
   output logic       tick,
   output logic       next_pulse,
   output logic       clr_err,
   output logic       set_erase_err,
   output logic       set_prog_err,
   output logic       set_vpp_err,
   output logic       set_lock_err
);
   wsm_state_t state_q, state_d;
   wsm_op_t    op_q, op_d;

   always_comb begin
      state_d       = state_q;
      op_d          = op_q;
      restart       = 1'b0;
      tick          = 1'b0;
      next_pulse    = 1'b0;
      clr_err       = 1'b0;
      set_erase_err = 1'b0;
      set_prog_err  = 1'b0;
      set_vpp_err   = 1'b0;
      set_lock_err  = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (cmd_clear) begin
               clr_err = 1'b1;
            end else if (cmd_program && cmd_erase) begin
               set_erase_err = 1'b1;
               set_prog_err  = 1'b1;
            end else if (cmd_program || cmd_erase) begin
               if (locked)        set_lock_err = 1'b1;
               else if (!vpp_ok)  set_vpp_err  = 1'b1;
               else begin
                  restart = 1'b1;
                  state_d = ST_RUN;
                  op_d    = cmd_erase ? OP_ERASE : OP_PROG;
               end
            end
         end
         ST_RUN: begin
            if (cmd_suspend) state_d = ST_SUSP;
            else begin
               tick = 1'b1;
               if (pulse_end) state_d = ST_VERIFY;
            end
         end
         ST_VERIFY: begin
            state_d = ST_IDLE;
            if (!vpp_ok) set_vpp_err = 1'b1;
            else if (verify_fail) begin
               if (op_q == OP_ERASE && !last_pulse) begin
                  next_pulse = 1'b1;
                  state_d    = ST_RUN;
               end else if (op_q == OP_ERASE) set_erase_err = 1'b1;
               else                           set_prog_err  = 1'b1;
            end
         end
         ST_SUSP: begin
            clr_err = cmd_clear;
            if (cmd_resume) state_d = ST_RUN;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         op_q    <= OP_PROG;
      end else begin
         state_q <= state_d;
         op_q    <= op_d;
      end
   end

   assign state = state_q;
   assign op    = op_q;
endmodule

// File: rtl/flash_wsm_status.sv
module flash_wsm_status
   import flash_wsm_pkg::*;
#(
   parameter int NUM_BLOCKS = 8,
   parameter int PULSE_CYC  = 4,
   parameter int MAX_PULSES = 3,
   parameter int BLK_W      = $clog2(NUM_BLOCKS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_program,
   input  logic             cmd_erase,
   input  logic             cmd_suspend,
   input  logic             cmd_resume,
   input  logic             cmd_clear,
   input  logic [BLK_W-1:0] blk_idx,
   input  logic             wp_n,
   input  logic             boot_top,
   input  logic             vpp_ok,
   input  logic             verify_fail,
   output logic [7:0]       status
);
   generate
      if (NUM_BLOCKS < 4)              begin : g_bad_blocks $error("NUM_BLOCKS must be at least 4"); end
      if ((1 << BLK_W) < NUM_BLOCKS)   begin : g_bad_width  $error("BLK_W too narrow for NUM_BLOCKS"); end
      if (PULSE_CYC < 1)               begin : g_bad_pulse  $error("PULSE_CYC must be positive"); end
      if (MAX_PULSES < 1)              begin : g_bad_max    $error("MAX_PULSES must be positive"); end
   endgenerate

   logic       locked, pulse_end, last_pulse, restart, tick, next_pulse;
   logic       clr_err, set_erase_err, set_prog_err, set_vpp_err, set_lock_err;
   wsm_state_t state;
   wsm_op_t    op;

   wsm_lock_check #(.NUM_BLOCKS(NUM_BLOCKS), .BLK_W(BLK_W)) u_lock (
      .blk_idx (blk_idx),
      .wp_n    (wp_n),
      .boot_top(boot_top),
      .locked  (locked)
   );

   wsm_pulse_timer #(.PULSE_CYC(PULSE_CYC), .MAX_PULSES(MAX_PULSES)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (restart),
      .tick      (tick),
      .next_pulse(next_pulse),
      .pulse_end (pulse_end),
      .last_pulse(last_pulse)
   );

   wsm_sequencer u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .cmd_program  (cmd_program),
      .cmd_erase    (cmd_erase),
      .cmd_suspend  (cmd_suspend),
      .cmd_resume   (cmd_resume),
      .cmd_clear    (cmd_clear),
      .locked       (locked),
      .vpp_ok       (vpp_ok),
      .verify_fail  (verify_fail),
      .pulse_end    (pulse_end),
      .last_pulse   (last_pulse),
      .state        (state),
      .op           (op),
      .restart      (restart),
      .tick         (tick),
      .next_pulse   (next_pulse),
      .clr_err      (clr_err),
      .set_erase_err(set_erase_err),
      .set_prog_err (set_prog_err),
      .set_vpp_err  (set_vpp_err),
      .set_lock_err (set_lock_err)
   );

   // sticky failure flags: erase, program, voltage, lock
   logic [3:0] err_q;
   always_ff @(posedge clk) begin
      if (!rst_n)       err_q <= '0;
      else if (clr_err) err_q <= '0;
      else              err_q <= err_q | {set_erase_err, set_prog_err, set_vpp_err, set_lock_err};
   end

   logic ready, halted;
   assign ready  = (state == ST_IDLE) || (state == ST_SUSP);
   assign halted = (state == ST_SUSP);

   assign status = {ready,
                    halted && (op == OP_ERASE),
                    err_q[3], err_q[2], err_q[1],
                    halted && (op == OP_PROG),
                    err_q[0],
                    1'b0};
endmodule

// File: rtl/wsm_status_chk.sv
module wsm_status_chk #(
   parameter int NUM_BLOCKS = 8,
   parameter int BLK_W      = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_program,
   input logic             cmd_erase,
   input logic             cmd_resume,
   input logic             cmd_clear,
   input logic [BLK_W-1:0] blk_idx,
   input logic             wp_n,
   input logic             boot_top,
   input logic [7:0]       status
);
   localparam logic [7:0] ERR_MASK = 8'h3A;

   logic idle_ready, tgt_locked;
   assign idle_ready = status[7] && !status[6] && !status[2];
   assign tgt_locked = !wp_n && (boot_top ? (blk_idx >= BLK_W'(NUM_BLOCKS - 2))
                                          : (blk_idx <= BLK_W'(1)));

   p_susp_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (status[6] || status[2]) |-> status[7]);

   p_susp_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(status[6] && status[2]));

   p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_clear |=> ((status & ERR_MASK) & $past(status & ERR_MASK)) == $past(status & ERR_MASK));

   p_clear_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_clear && !status[7]) |=> ((status & ERR_MASK) & $past(status & ERR_MASK)) == $past(status & ERR_MASK));

   p_lock_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_ready && cmd_program && !cmd_erase && !cmd_clear && tgt_locked) |=> (status[1] && status[7]));

   p_resume_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((status[6] || status[2]) && cmd_resume) |=> (!status[7] && !status[6] && !status[2]));

   p_seq_error_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_ready && cmd_program && cmd_erase && !cmd_clear) |=> (status[7] && status[5] && status[4]));
endmodule

bind flash_wsm_status wsm_status_chk #(.NUM_BLOCKS(NUM_BLOCKS), .BLK_W(BLK_W)) u_status_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_program(cmd_program),
   .cmd_erase  (cmd_erase),
   .cmd_resume (cmd_resume),
   .cmd_clear  (cmd_clear),
   .blk_idx    (blk_idx),
   .wp_n       (wp_n),
   .boot_top   (boot_top),
   .status     (status)
);

// File: tb/flash_wsm_status_bench.sv
module flash_wsm_status_bench;
   localparam int NB = 8;
   localparam int BW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_program = 0, cmd_erase = 0, cmd_suspend = 0, cmd_resume = 0, cmd_clear = 0;
   logic [BW-1:0] blk_idx = '0;
   logic wp_n = 1'b1, boot_top = 1'b0, vpp_ok = 1'b1, verify_fail = 1'b0;
   logic [7:0] status;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   flash_wsm_status #(.NUM_BLOCKS(NB), .PULSE_CYC(4), .MAX_PULSES(3), .BLK_W(BW)) u_flash_wsm_status (
      .clk(clk), .rst_n(rst_n),
      .cmd_program(cmd_program), .cmd_erase(cmd_erase), .cmd_suspend(cmd_suspend),
      .cmd_resume(cmd_resume), .cmd_clear(cmd_clear),
      .blk_idx(blk_idx), .wp_n(wp_n), .boot_top(boot_top),
      .vpp_ok(vpp_ok), .verify_fail(verify_fail), .status(status)
   );

   // fields: op[24:23] (1 prog, 2 erase, 3 both), blk[22:20], wp_n, boot_top, vpp_ok, verify_fail,
   //         expected final status[15:8], expected busy cycles[7:0]
   localparam logic [24:0] VEC [12] = '{
      {2'd1, 3'd5, 1'b1, 1'b1, 1'b1, 1'b0, 8'h80, 8'd5},  // R2 program passes
      {2'd2, 3'd3, 1'b0, 1'b0, 1'b1, 1'b0, 8'h80, 8'd5},  // R2 R5 erase, block 3 free in bottom mode
      {2'd1, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h82, 8'd0},  // R5 bottom block 0 locked
      {2'd2, 3'd7, 1'b0, 1'b1, 1'b1, 1'b0, 8'h82, 8'd0},  // R5 top block 7 locked
      {2'd2, 3'd6, 1'b0, 1'b1, 1'b1, 1'b0, 8'h82, 8'd0},  // R5 top block 6 locked
      {2'd1, 3'd6, 1'b0, 1'b0, 1'b1, 1'b0, 8'h80, 8'd5},  // R5 block 6 free in bottom mode
      {2'd1, 3'd1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h80, 8'd5},  // R5 protect high unlocks
      {2'd1, 3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 8'h88, 8'd0},  // R4 low voltage at entry
      {2'd1, 3'd2, 1'b1, 1'b0, 1'b1, 1'b1, 8'h90, 8'd5},  // R3 program verify fails
      {2'd2, 3'd2, 1'b1, 1'b0, 1'b1, 1'b1, 8'hA0, 8'd15}, // R3 erase exhausts pulses
      {2'd3, 3'd2, 1'b1, 1'b0, 1'b1, 1'b0, 8'hB0, 8'd0},  // R6 sequence error
      {2'd1, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h82, 8'd0}   // R5 lock wins over voltage
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic issue(input logic p, input logic e, input logic s, input logic r, input logic c);
      @(negedge clk);
      cmd_program = p; cmd_erase = e; cmd_suspend = s; cmd_resume = r; cmd_clear = c;
      step();
      cmd_program = 0; cmd_erase = 0; cmd_suspend = 0; cmd_resume = 0; cmd_clear = 0;
   endtask

   task automatic wait_ready(output int cyc);
      cyc = 0;
      while (!status[7] && cyc < 1000) begin
         step();
         cyc++;
      end
   endtask

   initial begin
      #100000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int cyc;
      repeat (3) step();
      @(negedge clk) rst_n = 1'b1;
      step();
      check("R1 reset status", status, 8'h80);

      for (int i = 0; i < 12; i++) begin
         issue(0, 0, 0, 0, 1);
         @(negedge clk);
         blk_idx = VEC[i][22:20]; wp_n = VEC[i][19]; boot_top = VEC[i][18];
         vpp_ok = VEC[i][17]; verify_fail = VEC[i][16];
         issue(VEC[i][23], VEC[i][24], 0, 0, 0);
         wait_ready(cyc);
         check($sformatf("R2/R3/R4/R5/R6 vector %0d status", i), status, VEC[i][15:8]);
         check($sformatf("R2/R3 vector %0d busy cycles", i), cyc, VEC[i][7:0]);
      end

      // R4: voltage dips between entry and verify only
      issue(0, 0, 0, 0, 1);
      @(negedge clk); wp_n = 1; vpp_ok = 1; verify_fail = 0; blk_idx = 3'd4;
      issue(1, 0, 0, 0, 0);
      @(negedge clk) vpp_ok = 0;
      step(); step();
      @(negedge clk) vpp_ok = 1;
      wait_ready(cyc);
      check("R4 dip between samples ignored", status, 8'h80);

      // R4: voltage low at verify aborts
      issue(1, 0, 0, 0, 0);
      @(negedge clk) vpp_ok = 0;
      wait_ready(cyc);
      check("R4 abort at verify status", status, 8'h88);
      check("R4 abort at verify cycles", cyc, 5);
      @(negedge clk) vpp_ok = 1;

      // R9: clear ignored while busy, sticky across a passing operation
      issue(1, 0, 0, 0, 0);
      check("R2 busy after accept", status, 8'h08);
      issue(0, 0, 0, 0, 1);
      check("R9 clear ignored while busy", status, 8'h08);
      wait_ready(cyc);
      check("R9 flag kept after pass", status, 8'h88);
      // R9: clear with program same cycle drops the program
      issue(1, 0, 0, 0, 1);
      check("R9 clear wins over program", status, 8'h80);
      step();
      check("R9 no busy after dropped program", status, 8'h80);

      // R7/R8: program suspend and resume
      issue(1, 0, 0, 0, 0);
      step();
      issue(0, 0, 1, 0, 0);
      check("R7 program suspended", status, 8'h84);
      issue(0, 1, 0, 0, 0);
      step();
      check("R7 erase ignored while suspended", status, 8'h84);
      issue(0, 0, 0, 1, 0);
      check("R8 resume clears suspend", status, 8'h00);
      wait_ready(cyc);
      check("R8 resume continues remaining cycles", cyc, 4);
      check("R8 program done after resume", status, 8'h80);

      // R7/R8: erase suspend and resume
      issue(0, 1, 0, 0, 0);
      step();
      issue(0, 0, 1, 0, 0);
      check("R7 erase suspended", status, 8'hC0);
      issue(0, 0, 0, 1, 0);
      check("R8 erase resumed busy", status, 8'h00);
      wait_ready(cyc);
      check("R8 erase remaining cycles", cyc, 4);

      // R7: suspend in verify cycle ignored
      issue(1, 0, 0, 0, 0);
      repeat (4) step();
      issue(0, 0, 1, 0, 0);
      check("R7 suspend in verify ignored", status, 8'h80);
      // R7/R8: suspend and resume while idle ignored
      issue(0, 0, 1, 0, 0);
      check("R7 suspend while idle ignored", status, 8'h80);
      issue(0, 0, 0, 1, 0);
      check("R8 resume while idle ignored", status, 8'h80);
      check("R1 reserved bit zero", {31'd0, status[0]}, 0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule